// File: doc/BRIEF.md
# Bridge Downstream Request Router

This block sits behind the upstream link of a bridge and takes one request at a time. It sends each request to one of three places. Memory requests that fall inside one of two address windows go to the secondary bus. Type 0 configuration requests are served from a small local set of window registers. Anything else is rejected. Type 1 configuration requests are rewritten into the compact type 0 address form and sent downstream. Their data bytes are reversed in both directions.

Every accepted request gets exactly one completion status. Requests complete in order, and only one is in flight at a time. The secondary side is a plain port. A one-cycle issue pulse goes out, and the port later returns one result with an outcome code and read data. The two windows (general memory and prefetchable memory) are compared against the live register contents. A write to a base or limit register therefore changes routing from the next accepted request on.

Top module: `dsreq_router`

## Requirements
- R1: A memory request (req_kind 0) is forwarded when base <= address < limit holds for the memory window or for the prefetchable window. A window's base and limit addresses are its register bits [15:4] placed at address bits [31:20], with the low bits zero. A forwarded memory request completes with status 3'b000 (successful) whatever downstream outcome code comes back, and returns ds_rdata unchanged.
- R2: A memory request outside both windows completes with status 3'b001 (unsupported) and is not forwarded. This includes an address equal to the limit or below the base.
- R3: A forwarded memory request carries ds_space 2'd1 when req_addr64 is set and 2'd0 otherwise. Its address and write data pass unchanged. Configuration forwards carry ds_space 2'd2.
- R4: I/O requests (req_kind 1) and message requests (req_kind 2) always complete with status 3'b001 and are never forwarded. Unknown kinds are handled the same way.
- R5: A type 1 configuration request (req_kind 4) is forwarded with ds_addr = {bus, devfn, reg} in bits [23:16], [15:8] and [7:0]. Here bus = req_addr[27:20], devfn = req_addr[19:12] and reg = req_addr[7:0]. All higher bits are zero.
- R6: The downstream outcome code of a type 1 request maps to the status. Code 0 gives 3'b000, code 1 gives 3'b100 (completer abort), and codes 2 and 3 give 3'b001.
- R7: A type 0 configuration request (req_kind 3) addresses local dwords 0x1C, 0x20 and 0x24 using req_addr[7:0]. The byte offset req_addr[1:0] must be aligned to the access size. A legal access completes with 3'b000. Any other dword, or a misaligned offset, gives 3'b100, and such a write changes no register.
- R8: Configuration data of 4 bytes is fully byte-reversed, and data of 2 bytes has its two low bytes swapped. This holds for write data and read data, local and forwarded. A single byte passes through in bits [7:0], and the unused upper bytes read as zero.
- R9: Local registers are laid out as follows.
  - Dword 0x1C holds the I/O base in byte 0 and the I/O limit in byte 1, each with write mask 0xF0. Bytes 2 and 3 read zero.
  - Dword 0x20 holds the memory base in bits [15:0] and the memory limit in bits [31:16], each with mask 0xFFF0 and reset 0.
  - Dword 0x24 holds the prefetchable base and limit in the same layout, with mask 0xFFF0 and reset 0x0001. Bits [3:0] stay 0x1.
- R10: A window whose base address is not below its limit address matches nothing. Routing follows the register contents from the request after the write.
- R11: The access size comes from req_be.
  - One set bit gives 1 byte.
  - Two adjacent set bits (0011, 0110, 1100) give 2 bytes.
  - 1111 gives 4 bytes.
  - Any other pattern is illegal. An illegal pattern gives 3'b100 for type 0, and 3'b001 without forwarding for type 1.
  - ds_size carries the size for forwarded requests.
- R12: req_ready is low from acceptance until the response cycle is over, so exactly one response is produced per request, in order. ds_valid is a one-cycle pulse. rsp_valid waits for ds_rsp_valid for however long it takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Router idle; request accepted when both high |
| req_kind | input | 3 | 0 memory, 1 I/O, 2 message, 3 config type 0, 4 config type 1 |
| req_write | input | 1 | Write when high |
| req_addr | input | ADDR_W | Request address |
| req_addr64 | input | 1 | Request used 64-bit addressing |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data as carried on the link |
| ds_valid | output | 1 | One-cycle downstream issue pulse |
| ds_space | output | 2 | 0 memory 32-bit, 1 memory 64-bit, 2 configuration |
| ds_write | output | 1 | Downstream write |
| ds_addr | output | ADDR_W | Downstream address |
| ds_be | output | 4 | Byte enables passed through |
| ds_size | output | 3 | Access size in bytes |
| ds_wdata | output | 32 | Downstream write data |
| ds_rsp_valid | input | 1 | Downstream result available |
| ds_rsp_code | input | 2 | 0 success, 1 master abort, 2/3 other failure |
| ds_rdata | input | 32 | Downstream read data |
| rsp_valid | output | 1 | Completion for the accepted request |
| rsp_status | output | 3 | 000 successful, 001 unsupported, 100 completer abort |
| rsp_rdata | output | 32 | Read data on the link, zero for writes and rejects |

## Verification
The bench probes the window edges: the address equal to the limit, the address one below the base, and windows that are disabled at reset or after a limit is lowered below its base. An off-by-one compare would forward these requests instead of rejecting them. It drives the byte-order paths with 1, 2 and 4 byte sizes, illegal byte-enable patterns and a misaligned local offset. A wrong swap or size decode shows up as reversed or shifted data, and an illegal access that wrongly succeeds shows up as the wrong status. It also holds the downstream result back for several cycles and checks that the mask and fixed-bit rules survive writes of all-ones patterns. A router that completed early, pulsed ds_valid twice or let the prefetchable low nibble change would fail these checks.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

   // request kinds on req_kind
   localparam logic [2:0] KIND_MEM  = 3'd0;
   localparam logic [2:0] KIND_IO   = 3'd1;
   localparam logic [2:0] KIND_MSG  = 3'd2;
   localparam logic [2:0] KIND_CFG0 = 3'd3;
   localparam logic [2:0] KIND_CFG1 = 3'd4;

   // completion status codes
   localparam logic [2:0] STS_SC = 3'b000;
   localparam logic [2:0] STS_UR = 3'b001;
   localparam logic [2:0] STS_CA = 3'b100;

   // downstream space tags
   localparam logic [1:0] SPC_MEM32 = 2'd0;
   localparam logic [1:0] SPC_MEM64 = 2'd1;
   localparam logic [1:0] SPC_CFG   = 2'd2;

   // downstream outcome codes
   localparam logic [1:0] DS_OK     = 2'd0;
   localparam logic [1:0] DS_MABORT = 2'd1;

   typedef enum logic [1:0] {
      RT_LOCAL  = 2'd0,
      RT_REJECT = 2'd1,
      RT_FWD    = 2'd2
   } route_e;

   // contiguous byte-enable pattern to byte count, 0 when illegal
   function automatic logic [2:0] be_size(input logic [3:0] be);
      case (be)
         4'b0001, 4'b0010, 4'b0100, 4'b1000: be_size = 3'd1;
         4'b0011, 4'b0110, 4'b1100:          be_size = 3'd2;
         4'b1111:                            be_size = 3'd4;
         default:                            be_size = 3'd0;
      endcase
   endfunction

   // byte order exchange between link and register views (self-inverse)
   function automatic logic [31:0] cfg_swap(input logic [31:0] d, input logic [2:0] size);
      case (size)
         3'd4:    cfg_swap = {d[7:0], d[15:8], d[23:16], d[31:24]};
         3'd2:    cfg_swap = {16'h0000, d[7:0], d[15:8]};
         3'd1:    cfg_swap = {24'h000000, d[7:0]};
         default: cfg_swap = 32'h0;
      endcase
   endfunction

endpackage

// File: rtl/dsr_window.sv
module dsr_window #(
   parameter int ADDR_W    = 64,
   parameter int FIELD_W   = 12,
   parameter int FIELD_LSB = 20
) (
   input  logic [FIELD_W-1:0] base_field,
   input  logic [FIELD_W-1:0] limit_field,
   input  logic [ADDR_W-1:0]  addr,
   output logic               enable,
   output logic               hit
);
   localparam int PAD_W = ADDR_W - FIELD_W;

   logic [ADDR_W-1:0] lo_addr;
   logic [ADDR_W-1:0] hi_addr;

   assign lo_addr = {{PAD_W{1'b0}}, base_field}  << FIELD_LSB;
   assign hi_addr = {{PAD_W{1'b0}}, limit_field} << FIELD_LSB;

   assign enable = lo_addr < hi_addr;
   assign hit    = enable && (addr >= lo_addr) && (addr < hi_addr);

endmodule

// File: rtl/dsr_cfgregs.sv
module dsr_cfgregs #(
   parameter int          OFF_W     = 8,
   parameter logic [15:0] MEM_MASK  = 16'hFFF0,
   parameter logic [15:0] PF_MASK   = 16'hFFF0,
   parameter logic [15:0] PF_RESET  = 16'h0001,
   parameter logic [7:0]  IO_MASK   = 8'hF0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [OFF_W-1:0] acc_off,
   input  logic [2:0]       acc_size,
   input  logic [31:0]      wr_native,
   output logic             acc_ok,
   output logic [31:0]      rd_native,
   output logic [11:0]      mem_base_f,
   output logic [11:0]      mem_limit_f,
   output logic [11:0]      pf_base_f,
   output logic [11:0]      pf_limit_f
);
   import dsr_pkg::*;

   localparam int                IDX_W   = OFF_W - 2;
   localparam logic [IDX_W-1:0]  IDX_IO  = IDX_W'(7);
   localparam logic [IDX_W-1:0]  IDX_MEM = IDX_W'(8);
   localparam logic [IDX_W-1:0]  IDX_PF  = IDX_W'(9);

   logic [7:0]  io_base_q, io_limit_q;
   logic [15:0] mem_base_q, mem_limit_q;
   logic [15:0] pf_base_q, pf_limit_q;

   logic [IDX_W-1:0] idx;
   logic [1:0]       boff;
   logic [4:0]       bsh;
   logic             idx_ok, align_ok;
   logic [31:0]      cur_dw, size_mask, lane_mask, merged;

   assign idx  = acc_off[OFF_W-1:2];
   assign boff = acc_off[1:0];
   assign bsh  = {boff, 3'b000};

   assign idx_ok = (idx == IDX_IO) || (idx == IDX_MEM) || (idx == IDX_PF);

   always_comb begin
      case (acc_size)
         3'd1:    begin align_ok = 1'b1;               size_mask = 32'h0000_00FF; end
         3'd2:    begin align_ok = (boff[0] == 1'b0);  size_mask = 32'h0000_FFFF; end
         3'd4:    begin align_ok = (boff == 2'b00);    size_mask = 32'hFFFF_FFFF; end
         default: begin align_ok = 1'b0;               size_mask = 32'h0000_0000; end
      endcase
   end

   assign acc_ok = idx_ok && align_ok;

   always_comb begin
      if (idx == IDX_IO)       cur_dw = {16'h0000, io_limit_q, io_base_q};
      else if (idx == IDX_MEM) cur_dw = {mem_limit_q, mem_base_q};
      else if (idx == IDX_PF)  cur_dw = {pf_limit_q, pf_base_q};
      else                     cur_dw = 32'h0;
   end

   assign lane_mask = size_mask << bsh;
   assign merged    = (cur_dw & ~lane_mask) | ((wr_native << bsh) & lane_mask);
   assign rd_native = (cur_dw >> bsh) & size_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         io_base_q   <= 8'h00;
         io_limit_q  <= 8'h00;
         mem_base_q  <= 16'h0000;
         mem_limit_q <= 16'h0000;
         pf_base_q   <= PF_RESET;
         pf_limit_q  <= PF_RESET;
      end else if (wr_en && acc_ok) begin
         if (idx == IDX_IO) begin
            io_base_q  <= merged[7:0]  & IO_MASK;
            io_limit_q <= merged[15:8] & IO_MASK;
         end
         if (idx == IDX_MEM) begin
            mem_base_q  <= merged[15:0]  & MEM_MASK;
            mem_limit_q <= merged[31:16] & MEM_MASK;
         end
         if (idx == IDX_PF) begin
            pf_base_q  <= (merged[15:0]  & PF_MASK) | (PF_RESET & ~PF_MASK);
            pf_limit_q <= (merged[31:16] & PF_MASK) | (PF_RESET & ~PF_MASK);
         end
      end
   end

   assign mem_base_f  = mem_base_q[15:4];
   assign mem_limit_f = mem_limit_q[15:4];
   assign pf_base_f   = pf_base_q[15:4];
   assign pf_limit_f  = pf_limit_q[15:4];

   AST_MEM_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_base_q[3:0] == 4'h0) && (mem_limit_q[3:0] == 4'h0)); // R9

   AST_PF_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_base_q[3:0] == PF_RESET[3:0]) && (pf_limit_q[3:0] == PF_RESET[3:0])); // R9

   AST_BAD_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !acc_ok) |=> ($stable(mem_base_q) && $stable(pf_base_q) && $stable(io_base_q))); // R7

endmodule

// File: rtl/dsr_seq.sv
module dsr_seq #(
   parameter int ADDR_W = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  accept,
   input  dsr_pkg::route_e       route,
   input  logic [2:0]            imm_status,
   input  logic [31:0]           imm_rdata,
   input  logic [1:0]            fwd_space,
   input  logic                  fwd_write,
   input  logic [ADDR_W-1:0]     fwd_addr,
   input  logic [3:0]            fwd_be,
   input  logic [2:0]            fwd_size,
   input  logic [31:0]           fwd_wdata,
   output logic                  req_ready,
   output logic                  ds_valid,
   output logic [1:0]            ds_space,
   output logic                  ds_write,
   output logic [ADDR_W-1:0]     ds_addr,
   output logic [3:0]            ds_be,
   output logic [2:0]            ds_size,
   output logic [31:0]           ds_wdata,
   input  logic                  ds_rsp_valid,
   input  logic [1:0]            ds_rsp_code,
   input  logic [31:0]           ds_rdata,
   output logic                  rsp_valid,
   output logic [2:0]            rsp_status,
   output logic [31:0]           rsp_rdata
);
   import dsr_pkg::*;

   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_ISSUE = 2'd1,
      S_WAIT  = 2'd2,
      S_RESP  = 2'd3
   } seq_state_e;

   seq_state_e        state_q;
   logic [1:0]        space_q;
   logic              write_q;
   logic [ADDR_W-1:0] addr_q;
   logic [3:0]        be_q;
   logic [2:0]        size_q;
   logic [31:0]       wdata_q;
   logic [2:0]        status_q;
   logic [31:0]       rdata_q;

   logic [2:0]        ds_status;
   logic [31:0]       ds_rd_link;

   always_comb begin
      if (space_q != SPC_CFG)           ds_status = STS_SC;
      else if (ds_rsp_code == DS_OK)     ds_status = STS_SC;
      else if (ds_rsp_code == DS_MABORT) ds_status = STS_CA;
      else                               ds_status = STS_UR;
   end

   always_comb begin
      if (write_q)                  ds_rd_link = 32'h0;
      else if (space_q == SPC_CFG)  ds_rd_link = cfg_swap(ds_rdata, size_q);
      else                          ds_rd_link = ds_rdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         space_q  <= SPC_MEM32;
         write_q  <= 1'b0;
         addr_q   <= '0;
         be_q     <= 4'h0;
         size_q   <= 3'd0;
         wdata_q  <= 32'h0;
         status_q <= STS_SC;
         rdata_q  <= 32'h0;
      end else begin
         case (state_q)
            S_IDLE: begin
               if (accept) begin
                  if (route == RT_FWD) begin
                     space_q <= fwd_space;
                     write_q <= fwd_write;
                     addr_q  <= fwd_addr;
                     be_q    <= fwd_be;
                     size_q  <= fwd_size;
                     wdata_q <= fwd_wdata;
                     state_q <= S_ISSUE;
                  end else begin
                     status_q <= imm_status;
                     rdata_q  <= imm_rdata;
                     state_q  <= S_RESP;
                  end
               end
            end
            S_ISSUE: state_q <= S_WAIT;
            S_WAIT: begin
               if (ds_rsp_valid) begin
                  status_q <= ds_status;
                  rdata_q  <= ds_rd_link;
                  state_q  <= S_RESP;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign req_ready  = (state_q == S_IDLE);
   assign ds_valid   = (state_q == S_ISSUE);
   assign ds_space   = space_q;
   assign ds_write   = write_q;
   assign ds_addr    = addr_q;
   assign ds_be      = be_q;
   assign ds_size    = size_q;
   assign ds_wdata   = wdata_q;
   assign rsp_valid  = (state_q == S_RESP);
   assign rsp_status = status_q;
   assign rsp_rdata  = rdata_q;

   AST_DS_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ds_valid |=> !ds_valid); // R12

   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready); // R12

   AST_CFG_MABORT_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == S_WAIT) && ds_rsp_valid && (space_q == SPC_CFG) && (ds_rsp_code == DS_MABORT))
      |=> (rsp_valid && (rsp_status == STS_CA))); // R6

   AST_MEM_FWD_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == S_WAIT) && ds_rsp_valid && (space_q != SPC_CFG))
      |=> (rsp_valid && (rsp_status == STS_SC))); // R1

endmodule

// File: rtl/dsreq_router.sv
module dsreq_router #(
   parameter int ADDR_W      = 64,
   parameter int BUS_SHIFT   = 20,
   parameter int DEVFN_SHIFT = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [2:0]        req_kind,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_addr64,
   input  logic [3:0]        req_be,
   input  logic [31:0]       req_wdata,
   output logic              ds_valid,
   output logic [1:0]        ds_space,
   output logic              ds_write,
   output logic [ADDR_W-1:0] ds_addr,
   output logic [3:0]        ds_be,
   output logic [2:0]        ds_size,
   output logic [31:0]       ds_wdata,
   input  logic              ds_rsp_valid,
   input  logic [1:0]        ds_rsp_code,
   input  logic [31:0]       ds_rdata,
   output logic              rsp_valid,
   output logic [2:0]        rsp_status,
   output logic [31:0]       rsp_rdata
);
   import dsr_pkg::*;

   localparam int NUM_WIN   = 2;
   localparam int FIELD_W   = 12;
   localparam int FIELD_LSB = 20;
   localparam int OFF_W     = 8;

   if (ADDR_W < 32) begin : g_bad_addr_w
      $error("dsreq_router: ADDR_W must be at least 32");
   end
   if (BUS_SHIFT + 8 > ADDR_W) begin : g_bad_bus_shift
      $error("dsreq_router: bus field exceeds the address width");
   end
   if ((DEVFN_SHIFT < 8) || (DEVFN_SHIFT + 8 > BUS_SHIFT)) begin : g_bad_devfn_shift
      $error("dsreq_router: devfn field overlaps the register or bus field");
   end

   logic              accept;
   logic [2:0]        acc_size;
   route_e            route;
   logic [2:0]        imm_status;
   logic [31:0]       imm_rdata;
   logic [1:0]        fwd_space;
   logic [ADDR_W-1:0] fwd_addr;
   logic [31:0]       fwd_wdata;
   logic [31:0]       wr_native;
   logic [31:0]       rd_native;
   logic              loc_ok;
   logic [ADDR_W-1:0] cfg1_addr;
   logic              cfg_wr_en;

   logic [FIELD_W-1:0] win_base  [NUM_WIN];
   logic [FIELD_W-1:0] win_limit [NUM_WIN];
   logic [NUM_WIN-1:0] win_en;
   logic [NUM_WIN-1:0] win_hit;

   assign accept    = req_valid && req_ready;
   assign acc_size  = be_size(req_be);
   assign wr_native = cfg_swap(req_wdata, acc_size);
   assign cfg_wr_en = accept && (req_kind == KIND_CFG0) && req_write;

   dsr_cfgregs #(
      .OFF_W (OFF_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (cfg_wr_en),
      .acc_off     (req_addr[OFF_W-1:0]),
      .acc_size    (acc_size),
      .wr_native   (wr_native),
      .acc_ok      (loc_ok),
      .rd_native   (rd_native),
      .mem_base_f  (win_base[0]),
      .mem_limit_f (win_limit[0]),
      .pf_base_f   (win_base[1]),
      .pf_limit_f  (win_limit[1])
   );

   for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
      dsr_window #(
         .ADDR_W    (ADDR_W),
         .FIELD_W   (FIELD_W),
         .FIELD_LSB (FIELD_LSB)
      ) u_win (
         .base_field  (win_base[gi]),
         .limit_field (win_limit[gi]),
         .addr        (req_addr),
         .enable      (win_en[gi]),
         .hit         (win_hit[gi])
      );
   end

   assign cfg1_addr = {{(ADDR_W-24){1'b0}},
                       req_addr[BUS_SHIFT +: 8],
                       req_addr[DEVFN_SHIFT +: 8],
                       req_addr[7:0]};

   always_comb begin
      route      = RT_REJECT;
      imm_status = STS_UR;
      imm_rdata  = 32'h0;
      fwd_space  = SPC_MEM32;
      fwd_addr   = req_addr;
      fwd_wdata  = req_wdata;
      case (req_kind)
         KIND_MEM: begin
            if (|win_hit) route = RT_FWD;
            fwd_space = req_addr64 ? SPC_MEM64 : SPC_MEM32;
         end
         KIND_CFG0: begin
            route = RT_LOCAL;
            if (loc_ok) begin
               imm_status = STS_SC;
               imm_rdata  = req_write ? 32'h0 : cfg_swap(rd_native, acc_size);
            end else begin
               imm_status = STS_CA;
            end
         end
         KIND_CFG1: begin
            if (acc_size != 3'd0) route = RT_FWD;
            fwd_space = SPC_CFG;
            fwd_addr  = cfg1_addr;
            fwd_wdata = req_write ? wr_native : 32'h0;
         end
         default: route = RT_REJECT;
      endcase
   end

   dsr_seq #(
      .ADDR_W (ADDR_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .accept       (accept),
      .route        (route),
      .imm_status   (imm_status),
      .imm_rdata    (imm_rdata),
      .fwd_space    (fwd_space),
      .fwd_write    (req_write),
      .fwd_addr     (fwd_addr),
      .fwd_be       (req_be),
      .fwd_size     (acc_size),
      .fwd_wdata    (fwd_wdata),
      .req_ready    (req_ready),
      .ds_valid     (ds_valid),
      .ds_space     (ds_space),
      .ds_write     (ds_write),
      .ds_addr      (ds_addr),
      .ds_be        (ds_be),
      .ds_size      (ds_size),
      .ds_wdata     (ds_wdata),
      .ds_rsp_valid (ds_rsp_valid),
      .ds_rsp_code  (ds_rsp_code),
      .ds_rdata     (ds_rdata),
      .rsp_valid    (rsp_valid),
      .rsp_status   (rsp_status),
      .rsp_rdata    (rsp_rdata)
   );

   AST_IO_MSG_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && ((req_kind == KIND_IO) || (req_kind == KIND_MSG)))
      |=> (rsp_valid && (rsp_status == STS_UR) && !ds_valid)); // R4

   AST_NO_FWD_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (req_kind == KIND_MEM) && (win_hit == '0))
      |=> (!ds_valid && rsp_valid && (rsp_status == STS_UR))); // R2

   AST_CFG1_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ds_valid && (ds_space == SPC_CFG)) |-> (ds_addr[ADDR_W-1:24] == '0)); // R5

   AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      ((win_en == '0) && accept && (req_kind == KIND_MEM)) |=> !ds_valid); // R10

   AST_CFG1_BAD_BE: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (req_kind == KIND_CFG1) && (acc_size == 3'd0))
      |=> (!ds_valid && (rsp_status == STS_UR))); // R11

endmodule

// File: tb/tb_dsreq_router.sv
module tb_dsreq_router;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 25;

   typedef struct packed {
      logic [2:0]  kind;
      logic        wr;
      logic [63:0] addr;
      logic        a64;
      logic [3:0]  be;
      logic [31:0] wdata;
      logic [1:0]  code;
      logic [31:0] dsrd;
      logic        fwd;
      logic [1:0]  space;
      logic [63:0] daddr;
      logic [31:0] dwdata;
      logic [2:0]  dsize;
      logic [2:0]  st;
      logic [31:0] rd;
      logic [7:0]  tag;
   } vec_t;

   // kind: 0 mem, 1 io, 2 msg, 3 cfg0, 4 cfg1; status 0 SC, 1 UR, 4 CA
   localparam vec_t VECS [NV] = '{
      // R9 reset value of prefetchable pair
      '{3'd3,1'b0,64'h24,1'b0,4'hF,32'h0,2'd0,32'h0, 1'b0,2'd0,64'h0,32'h0,3'd0, 3'd0,32'h0100_0100, 8'd9},
      // R10 windows disabled at reset
      '{3'd0,1'b0,64'h0010_0000,1'b0,4'hF,32'h0,2'd0,32'h0, 1'b0,2'd0,64'h0,32'h0,3'd0, 3'd1,32'h0, 8'd10},
      // R9 R8 write memory window, low nibble masked
      '{3'd3,1'b1,64'h20,1'b0,4'hF,32'h1100_3000,2'd0,32'h0, 1'b0,2'd0,64'h0,32'h0,3'd0, 3'd0,32'h0, 8'd9},
      '{3'd3,1'b0,64'h20,1'b0,4'hF,32'h0,2'd0,32'h0, 1'b0,2'd0,64'h0,32'h0,3'd0, 3'd0,32'h1000_3000, 8'd9},
      // R1 R3 base address hits, 32-bit tag
      '{3'd0,1'b0,64'h0010_0000,1'b0,4'hF,32'h0,2'd0,32'hCAFE_F00D, 1'b1,2'd0,64'h0010_0000,32'h0,3'd4, 3'd0,32'hCAFE_F00D, 8'd1},
      // R1 R3 64-bit tag, master abort still successful
      '{3'd0,1'b1,64'h002F_FFFC,1'b1,4'hF,32'h1234_5678,2'd1,32'h0, 1'b1,2'd1,64'h002F_FFFC,32'h1234_5678,3'd4, 3'd0,32'h0, 8'd3},
      // R2 address equal to limit
      '{3'd0,1'b0,64'h0030_0000,1'b0,4'hF,32'h0,2'd0,32'h0, 1'b0,2'd0,64'h0,32'h0,3'd0, 3'd1,32'h0, 8'd2},
      // R2 below base
      '{3'd0,1'b0,64'h000F_FFFF,1'b0,4'hF,32'h0,2'd0,32'h0, 1'b0,2'd0,64'h0,32'h0,3'd0, 3'd1,32'h0, 8'd2},
      // R4 io
      '{3'd1,1'b0,64'h10,1'b0,4'hF,32'h0,2'd0,32'h0, 1'b0,2'd0,64'h0,32'h0,3'd0, 3'd1,32'h0, 8'd4},
      // R4 message
      '{3'd2,1'b1,64'h0,1'b0,4'hF,32'h0,2'd0,32'h0, 1'b0,2'd0,64'h0,32'h0,3'd0, 3'd1,32'h0, 8'd4},
      // R5 R6 R8 type 1 read, 4 bytes
      '{3'd4,1'b0,64'h0051_A53C,1'b0,4'hF,32'h0,2'd0,32'h1122_3344, 1'b1,2'd2,64'h0005_1A3C,32'h0,3'd4, 3'd0,32'h4433_2211, 8'd5},
      // R6 R8 R11 type 1 write, 2 bytes, master abort
      '{3'd4,1'b1,64'h0051_A53C,1'b0,4'h3,32'h0000_ABCD,2'd1,32'h0, 1'b1,2'd2,64'h0005_1A3C,32'h0000_CDAB,3'd2, 3'd4,32'h0, 8'd6},
      // R6 R8 single byte, other failure
      '{3'd4,1'b0,64'h0051_A53C,1'b0,4'h1,32'h0,2'd2,32'hFFFF_FF5A, 1'b1,2'd2,64'h0005_1A3C,32'h0,3'd1, 3'd1,32'h0000_005A, 8'd8},
      // R9 prefetchable write, low nibble forced
      '{3'd3,1'b1,64'h24,1'b0,4'hF,32'h4000_5F00,2'd0,32'h0, 1'b0,2'd0,64'h0,32'h0,3'd0, 3'd0,32'h0, 8'd9},
      // R1 prefetchable window hit
      '{3'd0,1'b0,64'h0048_0000,1'b1,4'hF,32'h0,2'd3,32'hA5A5_A5A5, 1'b1,2'd1,64'h0048_0000,32'h0,3'd4, 3'd0,32'hA5A5_A5A5, 8'd1},
      '{3'd3,1'b0,64'h24,1'b0,4'hF,32'h0,2'd0,32'h0, 1'b0,2'd0,64'h0,32'h0,3'd0, 3'd0,32'h4100_5100, 8'd9},
      // R7 unknown dword
      '{3'd3,1'b0,64'h40,1'b0,4'hF,32'h0,2'd0,32'h0, 1'b0,2'd0,64'h0,32'h0,3'd0, 3'd4,32'h0, 8'd7},
      // R9 io base byte write, mask F0
      '{3'd3,1'b1,64'h1C,1'b0,4'h1,32'h0000_00FF,2'd0,32'h0, 1'b0,2'd0,64'h0,32'h0,3'd0, 3'd0,32'h0, 8'd9},
      '{3'd3,1'b0,64'h1C,1'b0,4'h3,32'h0,2'd0,32'h0, 1'b0,2'd0,64'h0,32'h0,3'd0, 3'd0,32'h0000_F000, 8'd9},
      // R11 illegal enables on local access
      '{3'd3,1'b0,64'h20,1'b0,4'h5,32'h0,2'd0,32'h0, 1'b0,2'd0,64'h0,32'h0,3'd0, 3'd4,32'h0, 8'd11},
      // R7 misaligned 2-byte local access
      '{3'd3,1'b0,64'h21,1'b0,4'h3,32'h0,2'd0,32'h0, 1'b0,2'd0,64'h0,32'h0,3'd0, 3'd4,32'h0, 8'd7},
      // R11 illegal enables on type 1, not forwarded
      '{3'd4,1'b0,64'h0051_A53C,1'b0,4'hA,32'h0,2'd0,32'h0, 1'b0,2'd0,64'h0,32'h0,3'd0, 3'd1,32'h0, 8'd11},
      // R10 lower memory limit to zero
      '{3'd3,1'b1,64'h22,1'b0,4'h3,32'h0000_0500,2'd0,32'h0, 1'b0,2'd0,64'h0,32'h0,3'd0, 3'd0,32'h0, 8'd10},
      '{3'd0,1'b0,64'h0010_0000,1'b0,4'hF,32'h0,2'd0,32'h0, 1'b0,2'd0,64'h0,32'h0,3'd0, 3'd1,32'h0, 8'd10},
      '{3'd3,1'b0,64'h20,1'b0,4'hF,32'h0,2'd0,32'h0, 1'b0,2'd0,64'h0,32'h0,3'd0, 3'd0,32'h1000_0000, 8'd10}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [2:0]  req_kind = 3'd0;
   logic        req_write = 1'b0;
   logic [63:0] req_addr = 64'h0;
   logic        req_addr64 = 1'b0;
   logic [3:0]  req_be = 4'h0;
   logic [31:0] req_wdata = 32'h0;
   logic        ds_valid;
   logic [1:0]  ds_space;
   logic        ds_write;
   logic [63:0] ds_addr;
   logic [3:0]  ds_be;
   logic [2:0]  ds_size;
   logic [31:0] ds_wdata;
   logic        ds_rsp_valid = 1'b0;
   logic [1:0]  ds_rsp_code = 2'd0;
   logic [31:0] ds_rdata = 32'h0;
   logic        rsp_valid;
   logic [2:0]  rsp_status;
   logic [31:0] rsp_rdata;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dsreq_router dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
      .req_write(req_write), .req_addr(req_addr), .req_addr64(req_addr64),
      .req_be(req_be), .req_wdata(req_wdata),
      .ds_valid(ds_valid), .ds_space(ds_space), .ds_write(ds_write),
      .ds_addr(ds_addr), .ds_be(ds_be), .ds_size(ds_size), .ds_wdata(ds_wdata),
      .ds_rsp_valid(ds_rsp_valid), .ds_rsp_code(ds_rsp_code), .ds_rdata(ds_rdata),
      .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata)
   );

   task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   // observed results of one request
   logic        o_fwd, o_got, o_bad;
   logic [1:0]  o_space;
   logic [63:0] o_daddr;
   logic [31:0] o_dwdata, o_rd;
   logic [2:0]  o_dsize, o_st;

   task automatic run_req(input logic [2:0] kind, input logic wr, input logic [63:0] addr,
                          input logic a64, input logic [3:0] be, input logic [31:0] wdata,
                          input logic [1:0] code, input logic [31:0] dsrd, input int delay);
      bit pend;
      int cnt;
      pend = 0; cnt = 0;
      o_fwd = 0; o_got = 0; o_bad = 0;
      o_space = 0; o_daddr = 0; o_dwdata = 0; o_dsize = 0; o_st = 0; o_rd = 0;
      for (int k = 0; k < 50 && !req_ready; k++) @(negedge clk);
      req_valid = 1'b1; req_kind = kind; req_write = wr; req_addr = addr;
      req_addr64 = a64; req_be = be; req_wdata = wdata;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < 60; k++) begin
         if (ds_rsp_valid) ds_rsp_valid = 1'b0;
         if (rsp_valid) begin
            o_got = 1; o_st = rsp_status; o_rd = rsp_rdata;
            break;
         end
         if (ds_valid) begin
            if (o_fwd) o_bad = 1;
            o_fwd = 1; o_space = ds_space; o_daddr = ds_addr;
            o_dwdata = ds_wdata; o_dsize = ds_size;
            pend = 1; cnt = delay;
         end else if (pend) begin
            if (cnt == 0) begin
               ds_rsp_valid = 1'b1; ds_rsp_code = code; ds_rdata = dsrd;
               pend = 0;
            end else begin
               cnt--;
               if (req_ready) o_bad = 1;
            end
         end
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (CLK_PERIOD * 1000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      check(req_ready == 1'b1, "R12 reset req_ready", 64'(req_ready), 64'h1);
      check(rsp_valid == 1'b0, "R12 reset rsp_valid", 64'(rsp_valid), 64'h0);
      check(ds_valid == 1'b0, "R12 reset ds_valid", 64'(ds_valid), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         run_req(VECS[i].kind, VECS[i].wr, VECS[i].addr, VECS[i].a64, VECS[i].be,
                 VECS[i].wdata, VECS[i].code, VECS[i].dsrd, 0);
         check(o_got == 1'b1, $sformatf("R12 vec %0d response seen (R%0d)", i, VECS[i].tag), 64'(o_got), 64'h1);
         check(o_fwd == VECS[i].fwd, $sformatf("vec %0d forward (R%0d)", i, VECS[i].tag), 64'(o_fwd), 64'(VECS[i].fwd));
         check(o_st == VECS[i].st, $sformatf("vec %0d status (R%0d)", i, VECS[i].tag), 64'(o_st), 64'(VECS[i].st));
         check(o_rd == VECS[i].rd, $sformatf("vec %0d read data (R%0d)", i, VECS[i].tag), 64'(o_rd), 64'(VECS[i].rd));
         if (VECS[i].fwd) begin
            check(o_space == VECS[i].space, $sformatf("R3 vec %0d space", i), 64'(o_space), 64'(VECS[i].space));
            check(o_daddr == VECS[i].daddr, $sformatf("R5 vec %0d ds address", i), o_daddr, VECS[i].daddr);
            check(o_dwdata == VECS[i].dwdata, $sformatf("R8 vec %0d ds write data", i), 64'(o_dwdata), 64'(VECS[i].dwdata));
            check(o_dsize == VECS[i].dsize, $sformatf("R11 vec %0d ds size", i), 64'(o_dsize), 64'(VECS[i].dsize));
         end
         check(o_bad == 1'b0, $sformatf("R12 vec %0d handshake", i), 64'(o_bad), 64'h0);
      end

      // R12 downstream result held back for six cycles
      run_req(3'd0, 1'b0, 64'h0048_0000, 1'b0, 4'hF, 32'h0, 2'd0, 32'h0BAD_CAFE, 6);
      check(o_bad == 1'b0, "R12 stall keeps ready low and single pulse", 64'(o_bad), 64'h0);
      check(o_fwd == 1'b1, "R1 stall request forwarded", 64'(o_fwd), 64'h1);
      check(o_rd == 32'h0BAD_CAFE, "R12 stall read data", 64'(o_rd), 64'h0BAD_CAFE);
      check(o_st == 3'd0, "R1 stall status", 64'(o_st), 64'h0);

      // R9 reset restores register values
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      run_req(3'd3, 1'b0, 64'h24, 1'b0, 4'hF, 32'h0, 2'd0, 32'h0, 0);
      check(o_rd == 32'h0100_0100, "R9 prefetchable pair after reset", 64'(o_rd), 64'h0100_0100);
      run_req(3'd3, 1'b0, 64'h20, 1'b0, 4'hF, 32'h0, 2'd0, 32'h0, 0);
      check(o_rd == 32'h0, "R9 memory pair after reset", 64'(o_rd), 64'h0);
      run_req(3'd0, 1'b0, 64'h0048_0000, 1'b0, 4'hF, 32'h0, 2'd0, 32'h0, 0);
      check(o_fwd == 1'b0 && o_st == 3'd1, "R10 window closed after reset", {o_fwd, o_st}, 64'h1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule